// File: doc/BRIEF.md
# USB Low-Speed Packet Sniffer

This block listens passively to the two data lines of a low-speed USB link. It is clocked so that one bit time lasts a fixed number of system clock cycles (32 by default). It does not recover a bit clock. Instead it measures the number of cycles between successive transitions on D+ and sorts each measured gap into one, two, three or more bit times, using thresholds placed half a bit time beyond each whole count. Gaps of this kind locate the synchronisation pattern. A short series of further gaps then names the packet identifier (PID).

For every recognised packet the block writes a compact record into a byte-wide capture memory through a valid/ready write port. The record holds the 4-bit PID code, then, for token and data packets, the low byte of every following edge gap. It ends with end-of-packet bytes. Software starts a capture with a buffer base and end address. The block runs until the write pointer reaches the end address, and then pulses `done`.

The write port is a stream. `mem_valid` rises with an address and a byte, and all three stay unchanged until a cycle in which `mem_ready` is high. A small internal queue of `FIFO_DEPTH` entries absorbs stalls. The capture itself cannot pause, because the line keeps moving. A byte produced while the queue is full is lost, but it still uses up its address. `done` is raised only after the queue has drained.

Top module: `usb_ls_sniffer`

## Requirements
- R1: After reset `busy`, `done` and `mem_valid` are low. A `start` pulse while idle makes `busy` high and `wr_ptr` equal to `buf_base` on the next cycle.
- R2: With T = BIT_CYC, a gap of at most 1.5T cycles counts as one bit, at most 2.5T as two bits, at most 3.5T as three bits, and anything longer as more. Each threshold value itself belongs to the shorter class.
- R3: Synchronisation needs three consecutive one-bit gaps. Any longer gap before that restarts the count, and a packet whose preamble never reaches three consecutive one-bit gaps writes nothing.
- R4: A three-bit gap that ends synchronisation selects a token. The next one-bit gap then selects IN/OUT over SETUP (0xD), and a further one-bit gap selects OUT (0x1) over IN (0x9).
- R5: A two-bit gap that ends synchronisation selects a handshake. A next gap of at most two bits selects ACK/NAK over STALL (0xE), and a further one-bit gap selects ACK (0x2) over NAK (0xA).
- R6: A gap longer than three bits that ends synchronisation selects data. The next one-bit gap selects DATA0 (0x3) over DATA1 (0xB).
- R7: The PID byte (upper nibble zero) is written at the edge that ends its tail (one tail gap after OUT, IN or ACK, two after the others). For token and data packets, every later gap is then written as its low 8 bits, one byte per edge.
- R8: For token and data packets, end-of-packet (both lines low and no D+ edge in that cycle) writes two bytes. The first is the low 8 bits of the cycles since the last D+ edge. The second is the last gap value.
- R9: For a handshake packet, end-of-packet writes one byte, which is the low 8 bits of the last gap before it.
- R10: Bytes go to consecutive addresses from `buf_base`. Once the pointer reaches or passes `buf_end` (latched at start), capture stops, no further bytes are written, `done` pulses for one cycle and `busy` falls.
- R11: `start` has no effect while `busy` is high. The pointer keeps running from its current value.
- R12: While `mem_valid` is high and `mem_ready` low, `mem_addr` and `mem_data` stay unchanged. Bytes leave in address order once `mem_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, BIT_CYC cycles per bit time |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a capture (ignored while busy) |
| buf_base | input | ADDR_W | First capture address |
| buf_end | input | ADDR_W | Capture stops when the pointer reaches this address |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle pulse when capture has stopped and drained |
| wr_ptr | output | ADDR_W | Next capture address |
| mem_valid | output | 1 | Write request to capture memory |
| mem_ready | input | 1 | Capture memory accepts the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | 8 | Write byte |

## Verification
The bench builds the block with BIT_CYC = 8, so the thresholds fall at 12, 20 and 28 cycles. It drives gaps exactly on and one cycle past each threshold, which keeps every packet to a few hundred cycles. ADDR_W = 8 lets a 256-entry bench memory mirror the whole address space, so it can detect any write past the end address. FIFO_DEPTH = 2 means a single two-byte handshake record, held back by a low `mem_ready`, fills the queue completely, which brings the stall behaviour within reach.

// File: rtl/usb_sniff_pkg.sv
package usb_sniff_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HUNT, ST_SYNC, ST_HS, ST_HS_AN, ST_TOK, ST_TOK_IO,
    ST_DAT, ST_SKIP, ST_PAYLOAD, ST_EOP2, ST_EOPW, ST_DRAIN
  } cap_state_e;

  typedef enum logic [1:0] {
    CLS_ONE, CLS_TWO, CLS_THREE, CLS_LONG
  } gap_class_e;

  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_DATA0 = 4'h3;
  localparam logic [3:0] PID_IN    = 4'h9;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_DATA1 = 4'hB;
  localparam logic [3:0] PID_SETUP = 4'hD;
  localparam logic [3:0] PID_STALL = 4'hE;

endpackage

// File: rtl/usb_edge_timer.sv
module usb_edge_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          dp,
  input  logic          dm,
  output logic          edge_stb,
  output logic          se0,
  output logic [TW-1:0] elapsed
);
  logic [2:0]    dp_sh;
  logic [1:0]    dm_sh;
  logic [TW-1:0] tc;
  logic [TW-1:0] last_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_sh <= 3'b000;
      dm_sh <= 2'b11;
    end else begin
      dp_sh <= {dp_sh[1:0], dp};
      dm_sh <= {dm_sh[0], dm};
    end
  end

  assign edge_stb = dp_sh[2] ^ dp_sh[1];
  assign se0      = !dp_sh[1] && !dm_sh[1];
  assign elapsed  = tc - last_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc        <= '0;
      last_edge <= TW'(1);
    end else if (clear) begin
      tc        <= '0;
      last_edge <= TW'(1);
    end else begin
      tc <= tc + TW'(1);
      if (edge_stb) last_edge <= tc;
    end
  end

  // R8
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb && !clear |=> elapsed == TW'(1));

endmodule

// File: rtl/usb_gap_classify.sv
module usb_gap_classify
  import usb_sniff_pkg::*;
#(
  parameter int BIT_CYC = 32,
  parameter int TW      = 16
) (
  input  logic [TW-1:0] elapsed,
  output gap_class_e    cls
);
  localparam int NCLS = 3;
  logic [NCLS-1:0] at_most;

  for (genvar k = 1; k <= NCLS; k++) begin : g_thr
    localparam int LIMIT = k * BIT_CYC + BIT_CYC / 2;
    assign at_most[k-1] = (elapsed <= TW'(LIMIT));
  end

  always_comb begin
    if (at_most[0])      cls = CLS_ONE;
    else if (at_most[1]) cls = CLS_TWO;
    else if (at_most[2]) cls = CLS_THREE;
    else                 cls = CLS_LONG;
  end

endmodule

// File: rtl/usb_rec_fifo.sv
module usb_rec_fifo #(
  parameter int EW    = 24,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [EW-1:0] in_ent,
  output logic          out_vld,
  input  logic          out_rdy,
  output logic [EW-1:0] out_ent,
  output logic          empty
);
  localparam int IW = $clog2(DEPTH);

  logic [EW-1:0] store [DEPTH];
  logic [IW-1:0] rd_idx, wr_idx;
  logic [IW:0]   cnt;
  logic          full, pop, acc;

  assign full    = (cnt == (IW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign out_vld = !empty;
  assign out_ent = store[rd_idx];
  assign pop     = out_vld && out_rdy;
  assign acc     = in_vld && (!full || pop);

  always_ff @(posedge clk) begin
    if (acc) store[wr_idx] <= in_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      wr_idx <= '0;
      cnt    <= '0;
    end else begin
      if (acc) wr_idx <= wr_idx + IW'(1);
      if (pop) rd_idx <= rd_idx + IW'(1);
      case ({acc, pop})
        2'b10:   cnt <= cnt + (IW+1)'(1);
        2'b01:   cnt <= cnt - (IW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R12
  held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_ent));

  // R12
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (IW+1)'(DEPTH));

endmodule

// File: rtl/usb_capture_fsm.sv
module usb_capture_fsm
  import usb_sniff_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [ADDR_W-1:0] buf_end,
  input  logic              edge_stb,
  input  logic              se0,
  input  logic [7:0]        gap_lo,
  input  gap_class_e        cls,
  input  logic              fifo_empty,
  output logic              clear,
  output logic              push_vld,
  output logic [ADDR_W-1:0] push_addr,
  output logic [7:0]        push_byte,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              busy,
  output logic              done
);
  cap_state_e        st, nxt;
  logic [1:0]        hunt_cnt, hunt_nxt;
  logic [1:0]        skip_n, skip_nxt;
  logic [3:0]        pid_r, pid_nxt;
  logic              to_pay, to_pay_nxt;
  logic [7:0]        last_gap;
  logic [ADDR_W-1:0] end_q;
  logic              do_push;
  logic [7:0]        push_val;
  logic [ADDR_W:0]   ptr_nx;
  logic              hit_end;

  assign ptr_nx  = {1'b0, wr_ptr} + (ADDR_W+1)'(1);
  assign hit_end = (ptr_nx >= {1'b0, end_q});
  assign clear   = (st == ST_IDLE) && start;
  assign busy    = (st != ST_IDLE);

  always_comb begin
    nxt        = st;
    hunt_nxt   = hunt_cnt;
    skip_nxt   = skip_n;
    pid_nxt    = pid_r;
    to_pay_nxt = to_pay;
    do_push    = 1'b0;
    push_val   = gap_lo;
    case (st)
      ST_IDLE: if (start) begin
        nxt      = ST_HUNT;
        hunt_nxt = 2'd0;
      end
      ST_HUNT: if (edge_stb) begin
        if (cls == CLS_ONE) begin
          if (hunt_cnt == 2'd2) nxt = ST_SYNC;
          else hunt_nxt = hunt_cnt + 2'd1;
        end else begin
          hunt_nxt = 2'd0;
        end
      end
      ST_SYNC: if (edge_stb) begin
        case (cls)
          CLS_ONE:   nxt = ST_SYNC;
          CLS_TWO:   nxt = ST_HS;
          CLS_THREE: nxt = ST_TOK;
          default:   nxt = ST_DAT;
        endcase
      end
      ST_HS: if (edge_stb) begin
        if (cls == CLS_ONE || cls == CLS_TWO) begin
          nxt = ST_HS_AN;
        end else begin
          nxt = ST_SKIP; pid_nxt = PID_STALL; skip_nxt = 2'd2; to_pay_nxt = 1'b0;
        end
      end
      ST_HS_AN: if (edge_stb) begin
        nxt        = ST_SKIP;
        to_pay_nxt = 1'b0;
        if (cls == CLS_ONE) begin
          pid_nxt = PID_ACK; skip_nxt = 2'd1;
        end else begin
          pid_nxt = PID_NAK; skip_nxt = 2'd2;
        end
      end
      ST_TOK: if (edge_stb) begin
        if (cls == CLS_ONE) begin
          nxt = ST_TOK_IO;
        end else begin
          nxt = ST_SKIP; pid_nxt = PID_SETUP; skip_nxt = 2'd2; to_pay_nxt = 1'b1;
        end
      end
      ST_TOK_IO: if (edge_stb) begin
        nxt        = ST_SKIP;
        skip_nxt   = 2'd1;
        to_pay_nxt = 1'b1;
        pid_nxt    = (cls == CLS_ONE) ? PID_OUT : PID_IN;
      end
      ST_DAT: if (edge_stb) begin
        nxt        = ST_SKIP;
        skip_nxt   = 2'd2;
        to_pay_nxt = 1'b1;
        pid_nxt    = (cls == CLS_ONE) ? PID_DATA0 : PID_DATA1;
      end
      ST_SKIP: if (edge_stb) begin
        if (skip_n == 2'd1) begin
          do_push  = 1'b1;
          push_val = {4'h0, pid_r};
          nxt      = to_pay ? ST_PAYLOAD : ST_EOPW;
        end else begin
          skip_nxt = skip_n - 2'd1;
        end
      end
      ST_PAYLOAD: begin
        if (edge_stb) begin
          do_push = 1'b1;
        end else if (se0) begin
          do_push = 1'b1;
          nxt     = ST_EOP2;
        end
      end
      ST_EOP2: begin
        do_push  = 1'b1;
        push_val = last_gap;
        nxt      = ST_HUNT;
        hunt_nxt = 2'd0;
      end
      ST_EOPW: if (!edge_stb && se0) begin
        do_push  = 1'b1;
        push_val = last_gap;
        nxt      = ST_HUNT;
        hunt_nxt = 2'd0;
      end
      ST_DRAIN: if (fifo_empty && !push_vld) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (do_push && hit_end) nxt = ST_DRAIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hunt_cnt  <= '0;
      skip_n    <= '0;
      pid_r     <= '0;
      to_pay    <= 1'b0;
      last_gap  <= '0;
      end_q     <= '0;
      wr_ptr    <= '0;
      push_vld  <= 1'b0;
      push_addr <= '0;
      push_byte <= '0;
      done      <= 1'b0;
    end else begin
      st        <= nxt;
      hunt_cnt  <= hunt_nxt;
      skip_n    <= skip_nxt;
      pid_r     <= pid_nxt;
      to_pay    <= to_pay_nxt;
      push_vld  <= do_push;
      push_addr <= wr_ptr;
      push_byte <= push_val;
      done      <= (st == ST_DRAIN) && (nxt == ST_IDLE);
      if (clear) begin
        wr_ptr <= buf_base;
        end_q  <= buf_end;
      end else if (do_push) begin
        wr_ptr <= ptr_nx[ADDR_W-1:0];
      end
      if (edge_stb && busy) last_gap <= gap_lo;
    end
  end

  // R1
  start_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && wr_ptr == $past(buf_base));

  // R10
  push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_vld |-> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !push_vld && $past(!push_vld) && st != ST_DRAIN && !do_push
      |=> $stable(wr_ptr));

endmodule

// File: rtl/usb_ls_sniffer.sv
module usb_ls_sniffer
  import usb_sniff_pkg::*;
#(
  parameter int BIT_CYC    = 32,
  parameter int TW         = 16,
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [ADDR_W-1:0] buf_end,
  input  logic              usb_dp,
  input  logic              usb_dm,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  localparam int EW = ADDR_W + 8;

  logic              clear, edge_stb, se0, fifo_empty, push_vld;
  logic [TW-1:0]     elapsed;
  gap_class_e        cls;
  logic [ADDR_W-1:0] push_addr;
  logic [7:0]        push_byte;
  logic [EW-1:0]     out_ent;

  usb_edge_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .dp(usb_dp), .dm(usb_dm),
    .edge_stb(edge_stb), .se0(se0), .elapsed(elapsed)
  );

  usb_gap_classify #(.BIT_CYC(BIT_CYC), .TW(TW)) u_cls (
    .elapsed(elapsed), .cls(cls)
  );

  usb_capture_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_base(buf_base),
    .buf_end(buf_end), .edge_stb(edge_stb), .se0(se0),
    .gap_lo(elapsed[7:0]), .cls(cls), .fifo_empty(fifo_empty),
    .clear(clear), .push_vld(push_vld), .push_addr(push_addr),
    .push_byte(push_byte), .wr_ptr(wr_ptr), .busy(busy), .done(done)
  );

  usb_rec_fifo #(.EW(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_vld(push_vld),
    .in_ent({push_addr, push_byte}), .out_vld(mem_valid),
    .out_rdy(mem_ready), .out_ent(out_ent), .empty(fifo_empty)
  );

  assign mem_addr = out_ent[EW-1:8];
  assign mem_data = out_ent[7:0];

endmodule

// File: tb/usb_ls_sniffer_bench.sv
`timescale 1ns/1ps
module usb_ls_sniffer_bench;
  localparam int B  = 8;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dp = 1'b0, dm = 1'b1, rdy = 1'b1;
  logic [AW-1:0] base = '0, bend = '0;
  logic busy, done, mv;
  logic [AW-1:0] wr_ptr, ma;
  logic [7:0] md;

  usb_ls_sniffer #(.BIT_CYC(B), .TW(16), .ADDR_W(AW), .FIFO_DEPTH(2)) u_usb_ls_sniffer (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_base(base), .buf_end(bend),
    .usb_dp(dp), .usb_dm(dm), .busy(busy), .done(done), .wr_ptr(wr_ptr),
    .mem_valid(mv), .mem_ready(rdy), .mem_addr(ma), .mem_data(md)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, done_cnt = 0, exp_ptr = 0;
  bit exp_stop = 0, finished = 0;
  logic [7:0] mem [256];
  bit wrf [256];
  logic [7:0] exp_b [256];
  bit exp_w [256];
  int pre [16]; int npre;
  int tail [8]; int ntail;
  int pay [16]; int npay;

  always @(negedge clk) begin
    #1;
    if (mv && rdy) begin mem[ma] = md; wrf[ma] = 1'b1; end
    if (done) done_cnt++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog(int n);
    wait_cyc(n);
    dp = ~dp; dm = ~dp;
  endtask

  task automatic expect_byte(int v);
    if (!exp_stop) begin
      exp_b[exp_ptr] = v[7:0]; exp_w[exp_ptr] = 1'b1; exp_ptr++;
      if (exp_ptr >= int'(bend)) exp_stop = 1'b1;
    end
  endtask

  task automatic std_sync();
    npre = 6;
    for (int i = 0; i < 6; i++) pre[i] = B;
  endtask

  task automatic set_tail(int n, int a, int b, int c, int d, int e);
    ntail = n; tail[0] = a; tail[1] = b; tail[2] = c; tail[3] = d; tail[4] = e;
  endtask

  task automatic do_start(int b0, int e0);
    base = b0[AW-1:0]; bend = e0[AW-1:0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    exp_ptr = b0; exp_stop = 1'b0;
  endtask

  // kind: 0 handshake, 1 token or data
  task automatic send(int kind, int pidb, bit synced, int gap);
    int last;
    bit eop_edge;
    tog(40);
    for (int i = 0; i < npre; i++) tog(pre[i]);
    for (int i = 0; i < ntail; i++) tog(tail[i]);
    if (synced) expect_byte(pidb);
    last = tail[ntail-1];
    for (int i = 0; i < npay; i++) begin
      tog(pay[i]);
      if (synced && kind == 1) expect_byte(pay[i]);
      last = pay[i];
    end
    wait_cyc(gap);
    eop_edge = dp;
    dp = 1'b0; dm = 1'b0;
    if (synced) begin
      if (kind == 1) begin
        if (eop_edge) begin expect_byte(gap); expect_byte(1); expect_byte(gap); end
        else begin expect_byte(gap); expect_byte(last); end
      end else begin
        expect_byte(eop_edge ? gap : last);
      end
    end
    wait_cyc(16);
    dm = 1'b1;
    wait_cyc(30);
  endtask

  task automatic verify(string req);
    for (int a = 0; a < 256; a++) begin
      if (exp_w[a] || wrf[a]) begin
        chk(wrf[a] == exp_w[a], req, int'(wrf[a]), int'(exp_w[a]));
        if (exp_w[a]) chk(mem[a] == exp_b[a], req, int'(mem[a]), int'(exp_b[a]));
      end
    end
    chk(int'(wr_ptr) == exp_ptr, req, int'(wr_ptr), exp_ptr);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(mv == 1'b0, "R1 mem_valid", int'(mv), 0);
  endtask

  task automatic t_end();
    do_start(0, 4);
    #1;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(int'(wr_ptr) == 0, "R1 ptr after start", int'(wr_ptr), 0);
    std_sync(); set_tail(4, 3*B, B, B, 2*B, 0);
    npay = 5; pay[0] = 16; pay[1] = 17; pay[2] = 18; pay[3] = 19; pay[4] = 20;
    send(1, 1, 1'b1, 24);
    verify("R10 stop at end");
    chk(busy == 1'b0, "R10 busy low", int'(busy), 0);
    chk(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
    npay = 1; pay[0] = 30;
    send(1, 1, 1'b0, 24);
    verify("R10 nothing after stop");
  endtask

  task automatic t_tokens();
    std_sync();
    set_tail(4, 3*B, B, B, 2*B, 0); npay = 2; pay[0] = 20; pay[1] = 260;
    send(1, 1, 1'b1, 24); verify("R4 R7 R8 OUT");
    set_tail(4, 3*B, B, 2*B, B, 0); npay = 1; pay[0] = 16;
    send(1, 9, 1'b1, 10); verify("R4 R8 IN");
    set_tail(4, 3*B, 2*B, B, 2*B, 0); npay = 0;
    send(1, 13, 1'b1, 30); verify("R4 R8 SETUP");
  endtask

  task automatic t_hs();
    std_sync(); npay = 0;
    set_tail(4, 2*B, 2*B, B, B, 0);       send(0, 2, 1'b1, 12);  verify("R5 R9 ACK");
    set_tail(5, 2*B, 2*B, 2*B, B, B);     send(0, 10, 1'b1, 20); verify("R5 R9 NAK");
    set_tail(4, 2*B, 3*B, B, B, 0);       send(0, 14, 1'b1, 16); verify("R5 R9 STALL");
  endtask

  task automatic t_data();
    std_sync();
    set_tail(4, 4*B, B, B, 2*B, 0); npay = 3; pay[0] = 8; pay[1] = 16; pay[2] = 24;
    send(1, 3, 1'b1, 14); verify("R6 R7 DATA0");
    set_tail(4, 4*B, 2*B, B, B, 0); npay = 1; pay[0] = 40;
    send(1, 11, 1'b1, 22); verify("R6 DATA1");
  endtask

  task automatic t_thresholds();
    npre = 6;
    for (int i = 0; i < 6; i++) pre[i] = 12;
    npay = 0;
    set_tail(4, 20, 20, 12, 12, 0); send(0, 2, 1'b1, 16);  verify("R2 20 is two bits");
    set_tail(4, 21, 12, 12, 16, 0); send(1, 1, 1'b1, 16);  verify("R2 21 is three bits");
    set_tail(4, 28, 12, 13, 12, 0); send(1, 9, 1'b1, 16);  verify("R2 28 three, 13 two");
    set_tail(4, 29, 12, 12, 13, 0); send(1, 3, 1'b1, 16);  verify("R2 29 is long");
  endtask

  task automatic t_hunt();
    npay = 0;
    npre = 6; pre[0] = B; pre[1] = B; pre[2] = 13; pre[3] = B; pre[4] = B; pre[5] = B;
    set_tail(4, 2*B, 2*B, B, B, 0); send(0, 2, 1'b1, 16); verify("R3 restart then sync");
    npre = 3; pre[0] = B; pre[1] = B; pre[2] = 13;
    set_tail(4, 16, 16, B, B, 0); send(0, 2, 1'b0, 20); verify("R3 no sync no write");
  endtask

  task automatic t_start_ignored();
    @(negedge clk);
    base = 8'h90; start = 1'b1;
    @(negedge clk); start = 1'b0; base = 8'h10;
    #1;
    chk(int'(wr_ptr) == exp_ptr, "R11 ptr kept", int'(wr_ptr), exp_ptr);
    std_sync(); npay = 0; set_tail(4, 2*B, 2*B, B, B, 0);
    send(0, 2, 1'b1, 12); verify("R11 writes continue");
  endtask

  task automatic t_backpressure();
    int first;
    first = exp_ptr;
    rdy = 1'b0;
    std_sync(); npay = 0; set_tail(4, 2*B, 2*B, B, B, 0);
    send(0, 2, 1'b1, 12);
    #1;
    chk(mv == 1'b1, "R12 valid held", int'(mv), 1);
    chk(int'(ma) == first, "R12 addr held", int'(ma), first);
    chk(md == 8'h02, "R12 data held", int'(md), 2);
    @(negedge clk); rdy = 1'b1;
    wait_cyc(10);
    verify("R12 drained in order");
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin wrf[a] = 0; exp_w[a] = 0; mem[a] = '0; exp_b[a] = '0; end
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_end();
    do_start(16, 240);
    #1;
    chk(int'(wr_ptr) == 16, "R1 ptr at base", int'(wr_ptr), 16);
    t_tokens();
    t_hs();
    t_data();
    t_thresholds();
    t_hunt();
    t_start_ignored();
    t_backpressure();
    verify("R7 final image");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule